// File: doc/BRIEF.md
# Audio Master Clock Generator

This block produces the clocks of a serial audio port from a fast reference clock. The reference clock `clk_i` runs at twice the internal base rate, so at 1024·fs when the 512·fs base is selected and at 768·fs when the 384·fs base is selected. From a frame position counter the block derives a master clock for an external codec, a bit clock, a left/right frame clock and a one-cycle sample strobe for a companion serializer. Every master-mode output comes straight from a flop, so no output carries a glitch.

A 3-bit ratio code selects the master clock as the base rate divided by a power of two. A word-width select picks 32 or 48 bit clocks per frame. When 48 bit clocks do not divide the 512·fs frame evenly, a phase accumulator spreads the edges over the frame. The ratio, base, width and slave selections are captured only while the run input is low. A running port therefore never changes timing in the middle of a frame.

In slave mode the port drives no clocks of its own. The bit and frame clocks of a master port pass straight through, the master clock output stays low, and the sample strobe follows the falling edges of the external frame clock after synchronization. Both ports then run at the same sample rate.

Top module: `audio_clk_gen`

## Requirements
- R1: With `base_lo_i`=0 a frame lasts 1024 `clk_i` cycles (512·fs base). With `base_lo_i`=1 a frame lasts 768 cycles (384·fs base). Frame position p counts 0 to frame−1 and then wraps to 0.
- R2: In master mode `lrclk_o` is low for frame positions below half the frame and high for the rest. It therefore toggles every half frame, which is 16 or 24 bit-clock periods.
- R3: With ratio code k on `mult_i`, `mclk_o` equals bit k of p. Its period is 2^(k+1) `clk_i` cycles, which gives 512, 256, 128, 64 or 32·fs on the 512 base and 384, 192, 96 or 48·fs on the 384 base.
- R4: Codes above the largest valid code are clamped to it. On the 512 base, codes 5 to 7 act as 4 (32·fs). On the 384 base, codes 4 to 7 act as 3 (48·fs).
- R5: `bclk_o` equals bit 0 of floor(p·S/F), where F is the frame length and S is 64 for `wide_i`=0 or 96 for `wide_i`=1. This gives 32 or 48 bit clocks per frame with the clock low at frame start. On the 512 base with `wide_i`=1 the half periods alternate between 10 and 11 cycles.
- R6: On any rising edge with `run_i` low, the counters return to position 0 and `mclk_o`, `sample_stb_o` and the master-mode `bclk_o` and `lrclk_o` all go low. Output values are registered. The outputs after the n-th consecutive edge with `run_i` high (n from 0) show position n mod F.
- R7: The four configuration inputs are captured only on edges with `run_i` low. Changing them while running has no effect until the run input has been low for one edge.
- R8: With slave mode captured, `bclk_o` follows `ext_bclk_i` and `lrclk_o` follows `ext_lrclk_i` combinationally, and `mclk_o` stays low.
- R9: In master mode `sample_stb_o` is high for one cycle at frame position 0. In slave mode with `run_i` high, it is high for the one cycle after the second rising edge of `clk_i` that samples `ext_lrclk_i` low following a high level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, twice the base rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; low stops the outputs and allows configuration capture |
| base_lo_i | input | 1 | Base select: 0 = 512·fs, 1 = 384·fs |
| mult_i | input | MULT_W (3) | Master clock ratio code |
| wide_i | input | 1 | Bit clocks per frame: 0 = 32, 1 = 48 |
| slave_i | input | 1 | 1 = take bit and frame clocks from another port |
| ext_bclk_i | input | 1 | Bit clock from the master port |
| ext_lrclk_i | input | 1 | Frame clock from the master port |
| mclk_o | output | 1 | Master clock for the codec |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock |
| sample_stb_o | output | 1 | One-cycle pulse at each frame start |

## Verification
The assertions assume that reset is applied from time zero. They also assume that each configuration value is set up during an edge with `run_i` low before the port runs with it, so the frame bound and the accumulator bound are checked against a base that cannot change under a running counter. The strobe assertions assume that the external frame clock holds each level for at least two reference cycles. The bench drives every input at the falling edge. It presents each new configuration for a full idle edge before raising run, changes the configuration inputs in the middle of a run only to show that they are ignored, and holds each level of the external frame clock for five cycles.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef struct packed {
    logic slave;
    logic wide;
    logic base_lo;
  } acg_mode_t;
endpackage

// File: rtl/acg_cfg_latch.sv
module acg_cfg_latch
  import acg_pkg::*;
#(
  parameter int MULT_W = 3,
  parameter int MAX_HI = 4,
  parameter int MAX_LO = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              base_lo_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              wide_i,
  input  logic              slave_i,
  output acg_mode_t         mode_o,
  output logic [MULT_W-1:0] code_o
);
  acg_mode_t         mode_q;
  logic [MULT_W-1:0] code_q, code_d, lim;

  always_comb begin
    lim    = base_lo_i ? MULT_W'(MAX_LO) : MULT_W'(MAX_HI);
    code_d = (mult_i > lim) ? lim : mult_i;
  end

  // capture only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      code_q <= '0;
    end else if (!run_i) begin
      mode_q <= '{slave: slave_i, wide: wide_i, base_lo: base_lo_i};
      code_q <= code_d;
    end
  end

  assign mode_o = mode_q;
  assign code_o = code_q;

  a_r7_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) |-> $stable(mode_q) && $stable(code_q));

  a_r4_code_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= (mode_q.base_lo ? MULT_W'(MAX_LO) : MULT_W'(MAX_HI)));
endmodule

// File: rtl/acg_frame_ctr.sv
module acg_frame_ctr #(
  parameter int F_HI  = 1024,
  parameter int F_LO  = 768,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             base_lo_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, last;

  assign last = base_lo_i ? CNT_W'(F_LO - 1) : CNT_W'(F_HI - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r1_frame_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/acg_bclk_nco.sv
module acg_bclk_nco #(
  parameter int F_HI   = 1024,
  parameter int F_LO   = 768,
  parameter int STEP_N = 64,
  parameter int STEP_W = 96,
  parameter int CNT_W  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic base_lo_i,
  input  logic wide_i,
  output logic phase_o
);
  localparam int AW = CNT_W + 1;

  logic [CNT_W-1:0] acc_q;
  logic             ph_q;
  logic [AW-1:0]    step, modulus, sum, diff;

  always_comb begin
    step    = wide_i ? AW'(STEP_W) : AW'(STEP_N);
    modulus = base_lo_i ? AW'(F_LO) : AW'(F_HI);
    sum     = {1'b0, acc_q} + step;
    diff    = sum - modulus;
  end

  // fractional divider: phase flips each time the accumulator wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run_i) begin
      acc_q <= '0;
      ph_q  <= 1'b0;
    end else if (sum >= modulus) begin
      acc_q <= diff[CNT_W-1:0];
      ph_q  <= ~ph_q;
    end else begin
      acc_q <= sum[CNT_W-1:0];
    end
  end

  assign phase_o = ph_q;

  a_r5_acc_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, acc_q} < modulus);
endmodule

// File: rtl/acg_lr_sync.sv
module acg_lr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lr_i,
  output logic fall_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= lr_i;
      s2_q <= s1_q;
    end
  end

  assign fall_o = s2_q & ~s1_q;
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int MULT_W      = 3,
  parameter int BASE_HI     = 512,
  parameter int BASE_LO     = 384,
  parameter int BCLK_NARROW = 32,
  parameter int BCLK_WIDE   = 48,
  parameter int MAX_HI      = 4,
  parameter int MAX_LO      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              base_lo_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              wide_i,
  input  logic              slave_i,
  input  logic              ext_bclk_i,
  input  logic              ext_lrclk_i,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              sample_stb_o
);
  localparam int F_HI   = 2 * BASE_HI;
  localparam int F_LO   = 2 * BASE_LO;
  localparam int CNT_W  = $clog2(F_HI);
  localparam int STEP_N = 2 * BCLK_NARROW;
  localparam int STEP_W = 2 * BCLK_WIDE;

  acg_mode_t         mode;
  logic [MULT_W-1:0] code;
  logic [CNT_W-1:0]  cnt, half;
  logic              phase, lr_fall;
  logic              mclk_q, bclk_q, lr_q, stb_q;

  acg_cfg_latch #(.MULT_W(MULT_W), .MAX_HI(MAX_HI), .MAX_LO(MAX_LO)) u_cfg (
    .clk_i, .rst_ni, .run_i, .base_lo_i, .mult_i, .wide_i, .slave_i,
    .mode_o(mode), .code_o(code)
  );

  acg_frame_ctr #(.F_HI(F_HI), .F_LO(F_LO), .CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .run_i, .base_lo_i(mode.base_lo), .cnt_o(cnt)
  );

  acg_bclk_nco #(
    .F_HI(F_HI), .F_LO(F_LO), .STEP_N(STEP_N), .STEP_W(STEP_W), .CNT_W(CNT_W)
  ) u_nco (
    .clk_i, .rst_ni, .run_i, .base_lo_i(mode.base_lo), .wide_i(mode.wide),
    .phase_o(phase)
  );

  acg_lr_sync u_sync (
    .clk_i, .rst_ni, .lr_i(ext_lrclk_i), .fall_o(lr_fall)
  );

  assign half = mode.base_lo ? CNT_W'(F_LO / 2) : CNT_W'(F_HI / 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else if (!run_i) begin
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      mclk_q <= ~mode.slave & cnt[code];
      bclk_q <= ~mode.slave & phase;
      lr_q   <= ~mode.slave & (cnt >= half);
      stb_q  <= mode.slave ? lr_fall : (cnt == '0);
    end
  end

  assign mclk_o       = mclk_q;
  assign bclk_o       = mode.slave ? ext_bclk_i  : bclk_q;
  assign lrclk_o      = mode.slave ? ext_lrclk_i : lr_q;
  assign sample_stb_o = stb_q;

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> !mclk_o && !sample_stb_o && (mode.slave || (!bclk_o && !lrclk_o)));

  a_r9_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |=> !sample_stb_o);

  a_r2_stb_frame_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o && !mode.slave |-> !lrclk_o && !bclk_o);

  a_r8_slave_mclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode.slave |-> !mclk_o);
endmodule

// File: tb/audio_clk_gen_tb_top.sv
module audio_clk_gen_tb_top;
  localparam int CLK_P = 10;

  logic       clk, rst_ni, run_i, base_lo_i, wide_i, slave_i;
  logic [2:0] mult_i;
  logic       ext_bclk_i, ext_lrclk_i;
  logic       mclk_o, bclk_o, lrclk_o, sample_stb_o;

  typedef struct {
    logic [3:0] v;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  audio_clk_gen dut_i (
    .clk_i(clk), .rst_ni, .run_i, .base_lo_i, .mult_i, .wide_i, .slave_i,
    .ext_bclk_i, .ext_lrclk_i, .mclk_o, .bclk_o, .lrclk_o, .sample_stb_o
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  // expected {mclk, bclk, lrclk, stb} at frame position p
  function automatic logic [3:0] model(int p, bit blo, int code, bit wide);
    int f    = blo ? 768 : 1024;
    int mx   = blo ? 3 : 4;
    int k    = (code > mx) ? mx : code;
    int step = wide ? 96 : 64;
    logic m  = ((p >> k) & 1) != 0;
    logic b  = (((p * step) / f) & 1) != 0;
    logic l  = p >= f / 2;
    logic s  = p == 0;
    return {m, b, l, s};
  endfunction

  // monitor: pop and compare a quarter period after each rising edge
  always @(posedge clk) begin
    exp_t       e;
    logic [3:0] act;
    #(CLK_P / 4);
    if (sb_q.size() > 0) begin
      e   = sb_q.pop_front();
      act = {mclk_o, bclk_o, lrclk_o, sample_stb_o};
      n_cmp++;
      if (act !== e.v) begin
        n_bad++;
        $display("FAIL %s actual=%b expected=%b", e.tag, act, e.v);
      end
    end
  end

  task automatic push(logic [3:0] v, string tag);
    exp_t e;
    e.v   = v;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic set_cfg(bit blo, int code, bit wide, bit slv);
    @(negedge clk);
    base_lo_i = blo;
    mult_i    = code[2:0];
    wide_i    = wide;
    slave_i   = slv;
    @(negedge clk);
  endtask

  task automatic run_master(bit blo, int code, bit wide, int n, string tag);
    int f = blo ? 768 : 1024;
    set_cfg(blo, code, wide, 1'b0);
    run_i = 1'b1;
    for (int i = 0; i < n; i++) push(model(i % f, blo, code, wide), tag);
    repeat (n) @(negedge clk);
    run_i = 1'b0;
    push(4'b0000, {tag, " stop R6"});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit p1, p2;
    rst_ni = 1'b0; run_i = 1'b0; base_lo_i = 1'b0; mult_i = 3'd0;
    wide_i = 1'b0; slave_i = 1'b0; ext_bclk_i = 1'b0; ext_lrclk_i = 1'b1;
    repeat (3) @(negedge clk);
    // reset state (R6)
    n_cmp++;
    if ({mclk_o, bclk_o, lrclk_o, sample_stb_o} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R6 reset actual=%b expected=0000",
               {mclk_o, bclk_o, lrclk_o, sample_stb_o});
    end
    rst_ni = 1'b1;
    @(negedge clk);

    run_master(1'b0, 0, 1'b0, 1030, "R1 R2 R3 R5 R9 b512 k0 narrow");
    run_master(1'b0, 4, 1'b1, 1100, "R3 R5 b512 k4 wide");
    run_master(1'b1, 2, 1'b1, 800,  "R1 R3 R5 b384 k2 wide");
    run_master(1'b1, 6, 1'b0, 800,  "R4 b384 code6 clamp");
    run_master(1'b0, 7, 1'b1, 300,  "R4 b512 code7 clamp");

    // R7: changes while running are ignored, then taken after a stop
    ext_bclk_i  = 1'b0;
    set_cfg(1'b0, 1, 1'b0, 1'b0);
    run_i = 1'b1;
    for (int i = 0; i < 600; i++) push(model(i, 1'b0, 1, 1'b0), "R7 held cfg");
    repeat (100) @(negedge clk);
    base_lo_i = 1'b1; mult_i = 3'd3; wide_i = 1'b1;
    repeat (500) @(negedge clk);
    run_i = 1'b0;
    push(4'b0000, "R7 stop R6");
    @(negedge clk);
    run_i = 1'b1;
    for (int i = 0; i < 800; i++) push(model(i % 768, 1'b1, 3, 1'b1), "R7 new cfg");
    repeat (800) @(negedge clk);
    run_i = 1'b0;
    push(4'b0000, "R7 stop2 R6");
    @(negedge clk);
    @(negedge clk);

    // R8/R9 slave pass-through and synchronized strobe
    set_cfg(1'b0, 0, 1'b0, 1'b1);
    run_i = 1'b1;
    p1 = 1'b1;
    p2 = 1'b1;
    for (int i = 0; i < 60; i++) begin
      bit l, b;
      l = ((i / 5) % 2) == 0;
      b = (i % 2) == 1;
      ext_lrclk_i = l;
      ext_bclk_i  = b;
      push({1'b0, b, l, p2 & ~p1}, "R8 R9 slave");
      p2 = p1;
      p1 = l;
      @(negedge clk);
    end
    run_i = 1'b0;
    push({1'b0, ext_bclk_i, ext_lrclk_i, 1'b0}, "R8 slave stop");
    @(negedge clk);
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule